// File: doc/BRIEF.md
# Decoded Micro-op Line Cache

This block keeps micro-operations that a decoder has already produced, so a later fetch of the same code can take them without decoding again. A fill port takes one single-micro-op instruction per beat, with its start address and byte length. An internal line builder packs consecutive instructions into lines and writes each closed line into a set-associative store. A lookup port takes a fetch address and, one cycle later, reports a hit or a miss. On a hit it returns the line's micro-ops, how many there are, and the address just after the line's last instruction, so the front end can chain straight to the next lookup.

Code is grouped into 32-byte aligned regions. Address bits [9:5] select one of 32 sets, and bits [31:10] form the tag. A line never crosses a region, never holds more than six micro-ops, and ends after any branch micro-op. Within one set, a single region may own no more than three ways. A line that would need a fourth way for its region is dropped. A flush input empties the whole store in one cycle.

Top module: `uop_line_cache`

## Requirements
- R1: After reset, rsp_valid is 0 and every lookup misses.
- R2: A lookup presented with lk_valid gives rsp_valid exactly one cycle later. It hits only if a stored line starts exactly at lk_addr. A hit returns rsp_count, the micro-ops with slot 0 in bits [15:0] of rsp_uops, and rsp_next, the address after the line's last instruction. A miss returns rsp_count 0.
- R3: A line closes once it holds 6 micro-ops, and the following instruction starts a new line.
- R4: An instruction with fill_branch set is the last one in its line, whether the branch is taken or not.
- R5: A line also closes after an instruction that has fill_end set. An incoming instruction that is not contiguous with the open line (its address differs from the open line's end address), or that lies in a different 32-byte region, starts a new line.
- R6: A lookup at an address inside a stored line, but not at that line's start, is a miss.
- R7: At most 3 ways of a set hold lines of the same 32-byte region. A new line that would need a fourth way is rejected, and the three lines already held are kept.
- R8: The set index is address bits [9:5] and the tag is bits [31:10]. Lines from up to 8 different regions coexist in one set.
- R9: A new line goes into an invalid way if the set has one. Otherwise tree pseudo-LRU picks the victim. After 8 fills into an empty set with no lookups in between, the next fill evicts the line that was filled first.
- R10: flush invalidates every line in one cycle and discards the line being built.
- R11: A new line whose start address equals a stored line's start address replaces that line rather than taking another way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines and drop the open line |
| fill_valid | input | 1 | Fill beat valid |
| fill_addr | input | 32 | Start address of the filled instruction |
| fill_len | input | 4 | Byte length of the instruction (1 to 15) |
| fill_uop | input | 16 | Decoded micro-op |
| fill_branch | input | 1 | The micro-op is a branch |
| fill_end | input | 1 | Last instruction of this decode run |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | A line starts at the looked-up address |
| rsp_count | output | 3 | Micro-ops in the returned line |
| rsp_uops | output | 96 | Micro-ops, slot i at bits [16i+15:16i] |
| rsp_next | output | 32 | Address following the returned line |

## Verification
A corrupted tag, start offset or valid bit shows up on the first lookup of the affected address, one cycle after the request, as a wrong rsp_hit. A bad packing decision in the line builder shows up as a wrong rsp_count or rsp_next on a lookup of that line's start address, and also as an unexpected miss at the following line. Faults in the region counter or the replacement tree stay hidden until a set fills up. They then show as a line that is present or missing against expectation, so the directed sets are filled past their limits, and random fills on a few sets push them to capacity.

// File: rtl/uop_line_cache.sv
module uop_line_cache #(
  parameter int ADDR_W       = 32,
  parameter int UOP_W        = 16,
  parameter int SETS         = 32,
  parameter int WAYS         = 8,
  parameter int UOPS         = 6,
  parameter int REGION_LIMIT = 3,
  parameter int REGION_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  fill_valid,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic [3:0]            fill_len,
  input  logic [UOP_W-1:0]      fill_uop,
  input  logic                  fill_branch,
  input  logic                  fill_end,
  input  logic                  lk_valid,
  input  logic [ADDR_W-1:0]     lk_addr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [2:0]            rsp_count,
  output logic [UOPS*UOP_W-1:0] rsp_uops,
  output logic [ADDR_W-1:0]     rsp_next
);
  localparam int OFF_W  = $clog2(REGION_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int CNT_W  = 3;
  localparam int RCNT_W = $clog2(WAYS + 1);
  localparam int LINE_W = UOPS * UOP_W;

  function automatic logic [WAY_W-1:0] plru_pick(input logic [WAYS-2:0] t);
    int n = 0;
    plru_pick = '0;
    for (int l = 0; l < WAY_W; l++) begin
      plru_pick[WAY_W-1-l] = t[n];
      n = 2 * n + 1 + int'(t[n]);
    end
  endfunction

  function automatic logic [WAYS-2:0] plru_use(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] w);
    int n = 0;
    plru_use = t;
    for (int l = 0; l < WAY_W; l++) begin
      plru_use[n] = ~w[WAY_W-1-l];
      n = 2 * n + 1 + int'(w[WAY_W-1-l]);
    end
  endfunction

  logic [WAYS-1:0]   vld    [SETS];
  logic [WAYS-2:0]   plru_q [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [OFF_W-1:0]  soff_q [SETS][WAYS];
  logic [ADDR_W-1:0] end_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q  [SETS][WAYS];
  logic [LINE_W-1:0] dat_q  [SETS][WAYS];

  // line builder
  logic              b_closed;
  logic [ADDR_W-1:0] b_start, b_end;
  logic [CNT_W-1:0]  b_cnt;
  logic [LINE_W-1:0] b_dat;
  // commit stage
  logic              c_vld;
  logic [ADDR_W-1:0] c_start, c_end;
  logic [CNT_W-1:0]  c_cnt;
  logic [LINE_W-1:0] c_dat;

  wire b_has = b_cnt != '0;
  wire joins = fill_valid && b_has && !b_closed && fill_addr == b_end &&
               fill_addr[ADDR_W-1:OFF_W] == b_start[ADDR_W-1:OFF_W];
  wire push  = b_has && (b_closed || (fill_valid && !joins));
  wire [ADDR_W-1:0] fill_next = fill_addr + ADDR_W'(fill_len);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      b_cnt    <= '0;
      b_closed <= 1'b0;
      c_vld    <= 1'b0;
    end else begin
      c_vld <= push;
      if (push) begin
        c_start <= b_start;
        c_end   <= b_end;
        c_cnt   <= b_cnt;
        c_dat   <= b_dat;
      end
      if (fill_valid && joins) begin
        b_dat[int'(b_cnt)*UOP_W +: UOP_W] <= fill_uop;
        b_cnt    <= b_cnt + 1'b1;
        b_end    <= fill_next;
        b_closed <= fill_branch || fill_end || b_cnt == CNT_W'(UOPS - 1);
      end else if (fill_valid) begin
        b_dat    <= LINE_W'(fill_uop);
        b_cnt    <= CNT_W'(1);
        b_start  <= fill_addr;
        b_end    <= fill_next;
        b_closed <= fill_branch || fill_end || UOPS == 1;
      end else if (push) begin
        b_cnt    <= '0;
        b_closed <= 1'b0;
      end
    end
  end

  // placement of the committed line
  wire [IDX_W-1:0] c_set = c_start[OFF_W +: IDX_W];
  wire [TAG_W-1:0] c_tag = c_start[ADDR_W-1 -: TAG_W];
  logic [WAYS-1:0]   same_rgn, same_line;
  logic [RCNT_W-1:0] rgn_cnt;
  logic [WAY_W-1:0]  vict, inv_idx, line_idx;
  logic              accept;

  always_comb begin
    inv_idx  = '0;
    line_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      same_rgn[w]  = vld[c_set][w] && tag_q[c_set][w] == c_tag;
      same_line[w] = same_rgn[w] && soff_q[c_set][w] == c_start[OFF_W-1:0];
      if (!vld[c_set][w]) inv_idx = WAY_W'(w);
      if (same_line[w]) line_idx = WAY_W'(w);
    end
    rgn_cnt = RCNT_W'($countones(same_rgn));
    vict    = (|same_line) ? line_idx : (&vld[c_set]) ? plru_pick(plru_q[c_set]) : inv_idx;
    accept  = c_vld && ((|same_line) || rgn_cnt < RCNT_W'(REGION_LIMIT));
  end

  // lookup
  wire [IDX_W-1:0] l_set = lk_addr[OFF_W +: IDX_W];
  logic [WAYS-1:0]  hitv;
  logic [WAY_W-1:0] hit_idx;
  logic             any_vld;

  always_comb begin
    hit_idx = '0;
    any_vld = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hitv[w] = vld[l_set][w] && tag_q[l_set][w] == lk_addr[ADDR_W-1 -: TAG_W] &&
                soff_q[l_set][w] == lk_addr[OFF_W-1:0];
      if (hitv[w]) hit_idx = WAY_W'(w);
    end
    for (int s = 0; s < SETS; s++) any_vld = any_vld || (|vld[s]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]    <= '0;
        plru_q[s] <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (accept) begin
        vld[c_set][vict] <= 1'b1;
        plru_q[c_set]    <= plru_use(plru_q[c_set], vict);
      end
      if (lk_valid && (|hitv) && !(accept && c_set == l_set))
        plru_q[l_set] <= plru_use(plru_q[l_set], hit_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q[c_set][vict]  <= c_tag;
      soff_q[c_set][vict] <= c_start[OFF_W-1:0];
      end_q[c_set][vict]  <= c_end;
      cnt_q[c_set][vict]  <= c_cnt;
      dat_q[c_set][vict]  <= c_dat;
    end
  end

  wire hit_now = (|hitv) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_count <= '0;
      rsp_uops  <= '0;
      rsp_next  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit   <= hit_now;
        rsp_count <= hit_now ? cnt_q[l_set][hit_idx] : '0;
        rsp_uops  <= hit_now ? dat_q[l_set][hit_idx] : '0;
        rsp_next  <= hit_now ? end_q[l_set][hit_idx] : '0;
      end
    end
  end

  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_count != 3'd0 && rsp_count <= 3'(UOPS)));
  p_build_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt <= CNT_W'(UOPS));
  p_branch_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_branch && !flush) |=> b_closed);
  p_region_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> rgn_cnt <= RCNT_W'(REGION_LIMIT));
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld);
  p_unique_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
endmodule

// File: tb/uop_line_cache_bench.sv
module uop_line_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [3:0]  fill_len = '0;
  logic [15:0] fill_uop = '0;
  logic        fill_branch = 1'b0;
  logic        fill_end = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_count;
  logic [95:0] rsp_uops;
  logic [31:0] rsp_next;

  always #5 clk = ~clk;

  uop_line_cache u_uop_line_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_len(fill_len),
    .fill_uop(fill_uop), .fill_branch(fill_branch), .fill_end(fill_end),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_count(rsp_count),
    .rsp_uops(rsp_uops), .rsp_next(rsp_next));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model for the random phase
  logic [31:0] m_start [64];
  logic [31:0] m_end   [64];
  int          m_n = 0;

  function automatic logic [15:0] uop_of(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] mk_addr(input int tag, input int set, input int off);
    return (32'(tag) << 10) | (32'(set) << 5) | 32'(off);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] a, input int len, input bit br, input bit en);
    fill_valid = 1'b1; fill_addr = a; fill_len = 4'(len);
    fill_uop = uop_of(a); fill_branch = br; fill_end = en;
    @(negedge clk);
    fill_valid = 1'b0; fill_branch = 1'b0; fill_end = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input bit ehit, input int ecnt,
                      input logic [31:0] enext, input string req);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == ehit, {req, " hit"}, 32'(rsp_hit), 32'(ehit));
    if (ehit) begin
      chk(rsp_count == 3'(ecnt), {req, " count"}, 32'(rsp_count), 32'(ecnt));
      chk(rsp_next == enext, {req, " next"}, rsp_next, enext);
      chk(rsp_uops[15:0] == uop_of(a), {req, " uop0"}, 32'(rsp_uops[15:0]), 32'(uop_of(a)));
    end else begin
      chk(rsp_count == 3'd0, {req, " miss count"}, 32'(rsp_count), 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rsp_valid == 1'b0, "R1 idle after reset", 32'(rsp_valid), 32'd0);
    look(32'h1000, 0, 0, 0, "R1 empty");

    // R3: eight 2-byte instructions, six per line
    for (int i = 0; i < 8; i++) beat(32'h1000 + 32'(2 * i), 2, 0, i == 7);
    settle();
    look(32'h1000, 1, 6, 32'h100C, "R3 full line");
    look(32'h100C, 1, 2, 32'h1010, "R3 next line");
    look(32'h1002, 0, 0, 0, "R6 mid line");
    look(32'h1008, 0, 0, 0, "R6 mid line");
    // R2: rsp_next chains to the following line
    look(32'h100C, 1, 2, 32'h1010, "R2 chain");

    // R4
    do_flush();
    beat(32'h2000, 3, 0, 0);
    beat(32'h2003, 2, 1, 0);
    beat(32'h2005, 1, 0, 1);
    settle();
    look(32'h2000, 1, 2, 32'h2005, "R4 branch close");
    look(32'h2005, 1, 1, 32'h2006, "R4 after branch");

    // R5: region crossing and discontinuity
    do_flush();
    beat(32'h301C, 4, 0, 0);
    beat(32'h3020, 4, 0, 1);
    beat(32'h5000, 2, 0, 0);
    beat(32'h5010, 2, 0, 1);
    settle();
    look(32'h301C, 1, 1, 32'h3020, "R5 region end");
    look(32'h3020, 1, 1, 32'h3024, "R5 new region");
    look(32'h5000, 1, 1, 32'h5002, "R5 jump close");
    look(32'h5010, 1, 1, 32'h5012, "R5 jump target");

    // R7
    do_flush();
    for (int i = 0; i < 4; i++) beat(32'h4000 + 32'(4 * i), 4, 1, 0);
    settle();
    look(32'h4000, 1, 1, 32'h4004, "R7 kept");
    look(32'h4004, 1, 1, 32'h4008, "R7 kept");
    look(32'h4008, 1, 1, 32'h400C, "R7 kept");
    look(32'h400C, 0, 0, 0, "R7 fourth rejected");

    // R11
    do_flush();
    beat(32'h6000, 2, 1, 0);
    settle();
    beat(32'h6000, 4, 1, 0);
    beat(32'h6004, 4, 1, 0);
    beat(32'h6008, 4, 1, 0);
    settle();
    look(32'h6000, 1, 1, 32'h6004, "R11 replaced");
    look(32'h6008, 1, 1, 32'h600C, "R11 no extra way");

    // R10: flush drops stored lines and the open line
    beat(32'h7000, 2, 0, 0);
    do_flush();
    beat(32'h7002, 2, 0, 1);
    settle();
    look(32'h6000, 0, 0, 0, "R10 line gone");
    look(32'h7000, 0, 0, 0, "R10 open line dropped");
    look(32'h7002, 1, 1, 32'h7004, "R10 fresh line");

    // R8/R9: nine regions into set 2
    do_flush();
    for (int t = 11; t < 20; t++) beat(mk_addr(t, 2, 0), 3, 1, 0);
    settle();
    look(mk_addr(11, 2, 0), 0, 0, 0, "R9 oldest evicted");
    for (int t = 12; t < 20; t++)
      look(mk_addr(t, 2, 0), 1, 1, mk_addr(t, 2, 3), "R8 regions coexist");

    // random phase on sets 8..15, tags 1..4
    do_flush();
    m_n = 0;
    for (int k = 0; k < 60; k++) begin
      int tg, st, of, ln, rc, sc, hit_i;
      logic [31:0] a;
      tg = 1 + int'($urandom % 4);
      st = 8 + int'($urandom % 8);
      of = int'($urandom % 32);
      ln = 1 + int'($urandom % 4);
      a = mk_addr(tg, st, of);
      rc = 0; sc = 0; hit_i = -1;
      for (int j = 0; j < m_n; j++) begin
        if (m_start[j][9:5] == 5'(st)) sc++;
        if (m_start[j][31:5] == a[31:5]) rc++;
        if (m_start[j] == a) hit_i = j;
      end
      if (hit_i >= 0) begin
        m_end[hit_i] = a + 32'(ln);
        beat(a, ln, 1, 0);
      end else if (rc >= 3) begin
        beat(a, ln, 1, 0);
      end else if (sc < 8 && m_n < 64) begin
        m_start[m_n] = a; m_end[m_n] = a + 32'(ln); m_n++;
        beat(a, ln, 1, 0);
      end
    end
    settle();
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a;
      int hi;
      if (k % 2 == 0 && m_n > 0) a = m_start[$urandom % m_n];
      else a = mk_addr(1 + int'($urandom % 4), 8 + int'($urandom % 8), int'($urandom % 32));
      hi = -1;
      for (int j = 0; j < m_n; j++) if (m_start[j] == a) hi = j;
      if (hi >= 0) look(a, 1, 1, m_end[hi], "R2 R7 R11 random hit");
      else look(a, 0, 0, 0, "R6 R7 random miss");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule